// File: doc/BRIEF.md
# Partitioned 8x16 Fixed-Point Multiplier

This block multiplies unsigned 8-bit pixel components by signed 16-bit coefficients, several lanes at a time. Each lane keeps the middle sixteen bits of its product and rounds half-up on the bit just below them. An opcode selects where the bytes and coefficients come from and where each lane result goes:

- per-lane coefficients;
- one coefficient shared by all lanes;
- the high or low byte of each 16-bit lane;
- a two-lane widened form whose results sit in 32-bit slots.

Operands arrive as two 64-bit words with a valid strobe. The result leaves a two-stage pipeline. Stage one forms the raw lane products. Stage two rounds them and packs them into the output word. A new operation may enter on every cycle.

Top module: `pmul8x16`

## Requirements
- R1: Opcode 0x031 pairs byte i of `src_a` (bits 8i+7:8i, i = 0..3) with 16-bit lane i of `src_b` (bits 16i+15:16i). Lane result i is placed at `result` bits 16i+15:16i.
- R2: Each lane forms the product of a zero-extended byte and a sign-extended 16-bit coefficient. The lane result is product bits 23:8 plus product bit 7, truncated to 16 bits, so a carry out of bit 15 wraps. For example, 0x01 times 0xFF80 yields 0x0000.
- R3: Opcode 0x033 applies `src_b` bits 31:16 as the coefficient of all four lanes. Opcode 0x035 applies `src_b` bits 15:0 to all four lanes. In both cases the bytes come from `src_a` as in R1, and the output placement is as in R1.
- R4: Opcode 0x036 takes the multiplicand of lane i from `src_a` bits 16i+15:16i+8. Opcode 0x037 takes it from `src_a` bits 16i+7:16i. In both cases coefficients and placement are as in R1.
- R5: Opcodes 0x038 and 0x039 use lanes 0 and 1 only. Their multiplicands follow R4: upper byte for 0x038, lower byte for 0x039. Lane i result lands at `result` bits 32i+22:32i+7, and every other result bit is zero.
- R6: An operation accepted with `in_valid` high at a rising edge appears on `result` with `out_valid` high after the following rising edge. Operations may arrive on consecutive cycles.
- R7: Any other opcode still produces `out_valid`, with a result of zero.
- R8: While `rst_n` is low, `out_valid` and `result` are zero.
- R9: In a cycle where `out_valid` is low, `result` keeps the value of the last completed operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are presented this cycle |
| opcode | input | 9 | Variant selector |
| src_a | input | 64 | Pixel byte operand |
| src_b | input | 64 | Coefficient operand |
| out_valid | output | 1 | `result` carries a completed operation |
| result | output | 64 | Packed lane results |

## Verification
The bench builds the block with its default parameters: four lanes, 8-bit pixels and 16-bit coefficients. At this size the extreme products are reachable, from 0xFF times 0x8000 to 0xFF times 0x7FFF. So are the round-up carry that wraps past 16 bits and the 7-bit offset of the widened slots. Random operands are mixed with directed corner values across all seven opcodes, a few undefined opcodes and idle gaps. These exercise back-to-back throughput, bits ignored by each variant, and the hold of the result between operations.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    localparam int OPC_W = 9;

    localparam logic [OPC_W-1:0] OPC_LANE     = 9'h031;
    localparam logic [OPC_W-1:0] OPC_BCAST_HI = 9'h033;
    localparam logic [OPC_W-1:0] OPC_BCAST_LO = 9'h035;
    localparam logic [OPC_W-1:0] OPC_UPPER    = 9'h036;
    localparam logic [OPC_W-1:0] OPC_LOWER    = 9'h037;
    localparam logic [OPC_W-1:0] OPC_WIDE_HI  = 9'h038;
    localparam logic [OPC_W-1:0] OPC_WIDE_LO  = 9'h039;

    typedef enum logic [2:0] {
        MODE_NONE     = 3'd0,
        MODE_LANE     = 3'd1,
        MODE_BCAST_HI = 3'd2,
        MODE_BCAST_LO = 3'd3,
        MODE_UPPER    = 3'd4,
        MODE_LOWER    = 3'd5,
        MODE_WIDE_HI  = 3'd6,
        MODE_WIDE_LO  = 3'd7
    } pmul_mode_e;

    function automatic pmul_mode_e decode_mode(input logic [OPC_W-1:0] opc);
        pmul_mode_e m;
        case (opc)
            OPC_LANE:     m = MODE_LANE;
            OPC_BCAST_HI: m = MODE_BCAST_HI;
            OPC_BCAST_LO: m = MODE_BCAST_LO;
            OPC_UPPER:    m = MODE_UPPER;
            OPC_LOWER:    m = MODE_LOWER;
            OPC_WIDE_HI:  m = MODE_WIDE_HI;
            OPC_WIDE_LO:  m = MODE_WIDE_LO;
            default:      m = MODE_NONE;
        endcase
        return m;
    endfunction

    function automatic logic is_wide(input pmul_mode_e m);
        return (m == MODE_WIDE_HI) || (m == MODE_WIDE_LO);
    endfunction

endpackage

// File: rtl/pmul_operand_sel.sv
module pmul_operand_sel
    import pmul_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  pmul_mode_e                      mode_i,
    input  logic [LANES*COEF_W-1:0]         src_a_i,
    input  logic [LANES*COEF_W-1:0]         src_b_i,
    output logic [LANES-1:0][PIX_W-1:0]     pix_o,
    output logic [LANES-1:0][COEF_W-1:0]    coef_o
);
    localparam int WIDE_LANES = LANES / 2;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            pix_o[i]  = '0;
            coef_o[i] = '0;
            case (mode_i)
                MODE_LANE: begin
                    pix_o[i]  = src_a_i[i*PIX_W +: PIX_W];
                    coef_o[i] = src_b_i[i*COEF_W +: COEF_W];
                end
                MODE_BCAST_HI: begin
                    pix_o[i]  = src_a_i[i*PIX_W +: PIX_W];
                    coef_o[i] = src_b_i[COEF_W +: COEF_W];
                end
                MODE_BCAST_LO: begin
                    pix_o[i]  = src_a_i[i*PIX_W +: PIX_W];
                    coef_o[i] = src_b_i[0 +: COEF_W];
                end
                MODE_UPPER: begin
                    pix_o[i]  = src_a_i[i*COEF_W+PIX_W +: PIX_W];
                    coef_o[i] = src_b_i[i*COEF_W +: COEF_W];
                end
                MODE_LOWER: begin
                    pix_o[i]  = src_a_i[i*COEF_W +: PIX_W];
                    coef_o[i] = src_b_i[i*COEF_W +: COEF_W];
                end
                MODE_WIDE_HI: begin
                    if (i < WIDE_LANES) begin
                        pix_o[i]  = src_a_i[i*COEF_W+PIX_W +: PIX_W];
                        coef_o[i] = src_b_i[i*COEF_W +: COEF_W];
                    end
                end
                MODE_WIDE_LO: begin
                    if (i < WIDE_LANES) begin
                        pix_o[i]  = src_a_i[i*COEF_W +: PIX_W];
                        coef_o[i] = src_b_i[i*COEF_W +: COEF_W];
                    end
                end
                default: begin
                    pix_o[i]  = '0;
                    coef_o[i] = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pmul_lane.sv
module pmul_lane #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  logic [PIX_W-1:0]          pix_i,
    input  logic [COEF_W-1:0]         coef_i,
    output logic [PIX_W+COEF_W-1:0]   prod_o
);
    localparam int PROD_W = PIX_W + COEF_W + 1;

    logic signed [PROD_W-1:0] full;

    assign full   = $signed({1'b0, pix_i}) * $signed(coef_i);
    assign prod_o = full[PROD_W-2:0];

    // R2: the product is negative exactly when a negative coefficient meets a nonzero byte
    always_comb begin
        if (!$isunknown({pix_i, coef_i})) begin
            assert_sign_R2: assert (full[PROD_W-1] == (coef_i[COEF_W-1] && (pix_i != '0)))
                else $error("lane product sign mismatch");
        end
    end

endmodule

// File: rtl/pmul_pack.sv
module pmul_pack #(
    parameter int LANES  = 4,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  logic                                  wide_i,
    input  logic [LANES-1:0][PIX_W+COEF_W-1:0]    prod_i,
    output logic [LANES*COEF_W-1:0]               result_o
);
    localparam int DATA_W      = LANES * COEF_W;
    localparam int WIDE_LANES  = LANES / 2;
    localparam int WIDE_STRIDE = DATA_W / WIDE_LANES;
    localparam int WIDE_OFS    = PIX_W - 1;

    logic [LANES-1:0][COEF_W-1:0] rounded;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            rounded[i] = prod_i[i][PIX_W +: COEF_W] + COEF_W'(prod_i[i][PIX_W-1]);
        end
        result_o = '0;
        for (int i = 0; i < LANES; i++) begin
            if (wide_i) begin
                if (i < WIDE_LANES) begin
                    result_o[i*WIDE_STRIDE+WIDE_OFS +: COEF_W] = rounded[i];
                end
            end else begin
                result_o[i*COEF_W +: COEF_W] = rounded[i];
            end
        end
    end

endmodule

// File: rtl/pmul8x16.sv
module pmul8x16
    import pmul_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [8:0]               opcode,
    input  logic [LANES*COEF_W-1:0]  src_a,
    input  logic [LANES*COEF_W-1:0]  src_b,
    output logic                     out_valid,
    output logic [LANES*COEF_W-1:0]  result
);
    localparam int DATA_W      = LANES * COEF_W;
    localparam int KEEP_W      = PIX_W + COEF_W;
    localparam int WIDE_LANES  = LANES / 2;
    localparam int WIDE_STRIDE = DATA_W / WIDE_LANES;
    localparam int WIDE_OFS    = PIX_W - 1;

    function automatic logic [DATA_W-1:0] wide_field_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < WIDE_LANES; i++) begin
            m[i*WIDE_STRIDE+WIDE_OFS +: COEF_W] = '1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] WIDE_MASK = wide_field_mask();

    typedef struct packed {
        logic                           valid;
        pmul_mode_e                     mode;
        logic [LANES-1:0][KEEP_W-1:0]   prod;
    } mul_stage_t;

    typedef struct packed {
        logic                valid;
        logic [DATA_W-1:0]   data;
    } pack_stage_t;

    typedef struct packed {
        mul_stage_t   s1;
        pack_stage_t  s2;
    } pipe_t;

    pipe_t state_d, state_q;

    pmul_mode_e                    mode_in;
    logic [LANES-1:0][PIX_W-1:0]   lane_pix;
    logic [LANES-1:0][COEF_W-1:0]  lane_coef;
    logic [LANES-1:0][KEEP_W-1:0]  lane_prod;
    logic [DATA_W-1:0]             packed_word;

    assign mode_in = decode_mode(opcode);

    pmul_operand_sel #(
        .LANES  (LANES),
        .PIX_W  (PIX_W),
        .COEF_W (COEF_W)
    ) u_sel (
        .mode_i  (mode_in),
        .src_a_i (src_a),
        .src_b_i (src_b),
        .pix_o   (lane_pix),
        .coef_o  (lane_coef)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pmul_lane #(
            .PIX_W  (PIX_W),
            .COEF_W (COEF_W)
        ) u_lane (
            .pix_i  (lane_pix[g]),
            .coef_i (lane_coef[g]),
            .prod_o (lane_prod[g])
        );
    end

    pmul_pack #(
        .LANES  (LANES),
        .PIX_W  (PIX_W),
        .COEF_W (COEF_W)
    ) u_pack (
        .wide_i   (is_wide(state_q.s1.mode)),
        .prod_i   (state_q.s1.prod),
        .result_o (packed_word)
    );

    always_comb begin
        state_d          = state_q;
        state_d.s1.valid = in_valid;
        if (in_valid) begin
            state_d.s1.mode = mode_in;
            state_d.s1.prod = lane_prod;
        end
        state_d.s2.valid = state_q.s1.valid;
        if (state_q.s1.valid) begin
            state_d.s2.data = packed_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.s2.valid;
    assign result    = state_q.s2.data;

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.s1.valid |=> out_valid)
        else $error("stage-one operation did not complete");

    assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.s1.valid |=> !out_valid)
        else $error("out_valid without an operation");

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.s1.valid |=> $stable(result))
        else $error("result changed while idle");

    assert_wide_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.s1.valid && is_wide(state_q.s1.mode)) |=> ((result & ~WIDE_MASK) == '0))
        else $error("widened result has bits outside its fields");

    assert_badop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.s1.valid && (state_q.s1.mode == MODE_NONE)) |=> (result == '0))
        else $error("undefined opcode gave a nonzero result");

endmodule

// File: tb/pmul8x16_tb.sv
module pmul8x16_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [8:0]  opcode = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model pipeline
    logic        m_v1 = 1'b0, m_v2 = 1'b0;
    logic [63:0] m_r1 = '0, m_r2 = '0;
    string       m_t1 = "R8", m_t2 = "R8";

    always #10 clk = ~clk;

    pmul8x16 u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .src_a     (src_a),
        .src_b     (src_b),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [15:0] ref_lane(logic [7:0] p, logic [15:0] c);
        int          prod;
        logic [31:0] bits;
        prod = int'(p) * int'($signed(c));
        bits = prod;
        return bits[23:8] + {15'd0, bits[7]};
    endfunction

    function automatic logic [63:0] ref_op(logic [8:0] op, logic [63:0] a, logic [63:0] b);
        logic [63:0] r;
        r = '0;
        case (op)
            9'h031: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[8*i +: 8], b[16*i +: 16]);
            9'h033: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[8*i +: 8], b[31:16]);
            9'h035: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[8*i +: 8], b[15:0]);
            9'h036: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[16*i+8 +: 8], b[16*i +: 16]);
            9'h037: for (int i = 0; i < 4; i++) r[16*i +: 16] = ref_lane(a[16*i +: 8], b[16*i +: 16]);
            9'h038: for (int i = 0; i < 2; i++) r[32*i+7 +: 16] = ref_lane(a[16*i+8 +: 8], b[16*i +: 16]);
            9'h039: for (int i = 0; i < 2; i++) r[32*i+7 +: 16] = ref_lane(a[16*i +: 8], b[16*i +: 16]);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(logic [8:0] op);
        case (op)
            9'h031:         return "R1";
            9'h033, 9'h035: return "R3";
            9'h036, 9'h037: return "R4";
            9'h038, 9'h039: return "R5";
            default:        return "R7";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(bit v, logic [8:0] op, logic [63:0] a, logic [63:0] b, string tag);
        in_valid = v;
        opcode   = op;
        src_a    = a;
        src_b    = b;
        @(posedge clk);
        if (m_v1) begin
            m_r2 = m_r1;
            m_t2 = m_t1;
        end
        m_v2 = m_v1;
        m_v1 = v;
        if (v) begin
            m_r1 = ref_op(op, a, b);
            m_t1 = tag;
        end
        @(negedge clk);
        check("R6", {63'd0, out_valid}, {63'd0, m_v2});
        check(m_v2 ? m_t2 : "R9", result, m_r2);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] ops [10];
        ops = '{9'h031, 9'h033, 9'h035, 9'h036, 9'h037, 9'h038, 9'h039, 9'h032, 9'h000, 9'h1ff};

        repeat (3) @(negedge clk);
        check("R8", {63'd0, out_valid}, 64'd0);
        check("R8", result, 64'd0);
        rst_n = 1'b1;

        // R2: rounding, extremes and 16-bit wrap after round-up
        step(1'b1, 9'h031, 64'h0000_0000_FF01_FF01, 64'h8000_0080_7FFF_FF80, "R2");
        step(1'b0, 9'h000, '0, '0, "R9");
        check("R2", result, 64'h8080_0001_7F7F_0000);

        // R5: widened placement at bit 7
        step(1'b1, 9'h038, 64'h0000_0000_0300_0200, 64'hFFFF_FFFF_0100_0100, "R5");
        step(1'b1, 9'h039, 64'hFFFF_FFFF_FF01_FF02, 64'hAAAA_AAAA_FFFF_0100, "R5");
        check("R5", result, 64'h0000_0180_0000_0100);
        step(1'b0, 9'h000, '0, '0, "R9");

        // R3: shared coefficient upper/lower
        step(1'b1, 9'h033, 64'h1234_5678_0102_0304, 64'h0000_0000_0200_FFFF, "R3");
        step(1'b1, 9'h035, 64'h1234_5678_0102_0304, 64'h0000_0000_0200_FFFF, "R3");
        step(1'b1, 9'h036, 64'hFF00_8000_0100_7F00, 64'h7FFF_8000_1234_FFFF, "R4");
        step(1'b1, 9'h037, 64'h00FF_0080_0001_007F, 64'h7FFF_8000_1234_FFFF, "R4");
        step(1'b1, 9'h077, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
        step(1'b0, 9'h031, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_7FFF_7FFF_7FFF, "R9");
        step(1'b0, 9'h000, '0, '0, "R9");

        for (int n = 0; n < 800; n++) begin
            logic [8:0] op;
            bit         v;
            op = ops[$urandom % 10];
            v  = ($urandom % 4) != 0;
            step(v, op, {$urandom, $urandom}, {$urandom, $urandom}, tag_of(op));
        end
        step(1'b0, 9'h000, '0, '0, "R9");
        step(1'b0, 9'h000, '0, '0, "R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule